// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block joins two parallel data buses, called A and B, through a word split into independent halves. Each pin is modelled as a separate input, output value and output enable, so the surrounding logic resolves the pads and no tristate nets appear inside the block. Each half has its own storage register for each bus. Its output multiplexers forward either live data from the opposite bus or the stored value of that bus's register.

Each half has its own controls. An active-low enable isolates both sides of that half. A direction bit picks which side is driven. Two selects pick between live and stored data for each direction. Two capture strobes load the registers. A strobe is sampled on the block clock, and a register loads when its strobe is seen high after having been low at the previous edge. Loading happens whatever the enable and direction settings are. When the block drives a side, the register of that side stores the driven value.

Top module: `xcvr_regbus`

## Requirements
- R1: After the asynchronous active-low reset `rst_ni`, every register holds zero. A stored-mode output therefore reads zero until a capture occurs.
- R2: While `oe_ni[h]` is 1, every bit of `a_oe_o` and `b_oe_o` in half h is 0.
- R3: While `oe_ni[h]` is 0, `dir_i[h]`=1 sets all of half h's `b_oe_o` bits and clears its `a_oe_o` bits. `dir_i[h]`=0 does the reverse. The A and B enables of a half are never set together.
- R4: When half h drives B and `sel_ab_i[h]`=0, the half's bits of `b_o` equal the same bits of `a_i` in the same cycle.
- R5: When half h drives A and `sel_ba_i[h]`=0, the half's bits of `a_o` equal the same bits of `b_i` in the same cycle.
- R6: When `sel_ab_i[h]`=1, the half's `b_o` bits show the A register of half h. That register loads at a clock edge where `cap_ab_i[h]` is 1 and was 0 at the previous edge, and the new value appears on `b_o` right after that edge.
- R7: When `sel_ba_i[h]`=1, the half's `a_o` bits show the B register of half h. That register loads under the same rule as R6, using `cap_ba_i[h]`.
- R8: Captures take place regardless of `oe_ni` and `dir_i`, including while the half is isolated.
- R9: While half h drives A, its A register captures the driven `a_o` value, not `a_i`. While it drives B, its B register captures `b_o`.
- R10: Controls of half h affect only bits [h*HALF_W +: HALF_W]. Bit h of each control vector belongs to half h.
- R11: A strobe held high over several edges causes exactly one load, at its first edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock; strobes are sampled on its rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset |
| oe_ni | input | NUM_HALVES | Per-half active-low output enable |
| dir_i | input | NUM_HALVES | Per-half direction: 1 drives B, 0 drives A |
| cap_ab_i | input | NUM_HALVES | Per-half A register capture strobe |
| cap_ba_i | input | NUM_HALVES | Per-half B register capture strobe |
| sel_ab_i | input | NUM_HALVES | Per-half B output source: 0 live A, 1 stored A |
| sel_ba_i | input | NUM_HALVES | Per-half A output source: 0 live B, 1 stored B |
| a_i | input | NUM_HALVES*HALF_W | Value seen on the A pins |
| a_o | output | NUM_HALVES*HALF_W | Value the block drives onto A |
| a_oe_o | output | NUM_HALVES*HALF_W | Per-pin drive enable for A |
| b_i | input | NUM_HALVES*HALF_W | Value seen on the B pins |
| b_o | output | NUM_HALVES*HALF_W | Value the block drives onto B |
| b_oe_o | output | NUM_HALVES*HALF_W | Per-pin drive enable for B |

## Verification
A capture into a register can coincide with that register being shown in stored mode. The opposite output must then change to the new value right after the same edge. It can also coincide with the register's own side being driven, and then the register must take the driven value rather than the pin input. The bench provokes both cases with directed sequences and also with random strobes, selects and directions. It judges every cycle against a behavioural model that updates its registers at the clock edge, and compares the enables and the enabled output bits mid-cycle.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
  typedef struct packed {
    logic oe_n;
    logic dir;
    logic cap_ab;
    logic cap_ba;
    logic sel_ab;
    logic sel_ba;
  } half_ctrl_t;
endpackage

// File: rtl/xcvr_cap_reg.sv
module xcvr_cap_reg #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         strobe_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic strobe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      strobe_q <= 1'b0;
      q_o      <= '0;
    end else begin
      strobe_q <= strobe_i;
      if (strobe_i && !strobe_q) q_o <= d_i;
    end
  end
endmodule

// File: rtl/xcvr_half.sv
module xcvr_half
  import xcvr_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  half_ctrl_t   ctrl_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] a_o,
  output logic [W-1:0] a_oe_o,
  output logic [W-1:0] b_o,
  output logic [W-1:0] b_oe_o
);
  logic         a_drive, b_drive;
  logic [W-1:0] reg_a, reg_b, a_src, b_src;

  assign a_drive = !ctrl_i.oe_n && !ctrl_i.dir;
  assign b_drive = !ctrl_i.oe_n &&  ctrl_i.dir;

  assign a_o = ctrl_i.sel_ba ? reg_b : b_i;
  assign b_o = ctrl_i.sel_ab ? reg_a : a_i;

  // a driven side stores what the block places on it
  assign a_src = a_drive ? a_o : a_i;
  assign b_src = b_drive ? b_o : b_i;

  assign a_oe_o = {W{a_drive}};
  assign b_oe_o = {W{b_drive}};

  xcvr_cap_reg #(.W(W)) i_reg_a (
    .clk_i, .rst_ni, .strobe_i(ctrl_i.cap_ab), .d_i(a_src), .q_o(reg_a)
  );

  xcvr_cap_reg #(.W(W)) i_reg_b (
    .clk_i, .rst_ni, .strobe_i(ctrl_i.cap_ba), .d_i(b_src), .q_o(reg_b)
  );
endmodule

// File: rtl/xcvr_regbus.sv
module xcvr_regbus
  import xcvr_pkg::*;
#(
  parameter int HALF_W     = 8,
  parameter int NUM_HALVES = 2,
  localparam int W         = HALF_W * NUM_HALVES
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [NUM_HALVES-1:0] oe_ni,
  input  logic [NUM_HALVES-1:0] dir_i,
  input  logic [NUM_HALVES-1:0] cap_ab_i,
  input  logic [NUM_HALVES-1:0] cap_ba_i,
  input  logic [NUM_HALVES-1:0] sel_ab_i,
  input  logic [NUM_HALVES-1:0] sel_ba_i,
  input  logic [W-1:0]          a_i,
  output logic [W-1:0]          a_o,
  output logic [W-1:0]          a_oe_o,
  input  logic [W-1:0]          b_i,
  output logic [W-1:0]          b_o,
  output logic [W-1:0]          b_oe_o
);
  for (genvar h = 0; h < NUM_HALVES; h++) begin : g_half
    half_ctrl_t ctrl;

    assign ctrl = '{oe_n:   oe_ni[h],
                    dir:    dir_i[h],
                    cap_ab: cap_ab_i[h],
                    cap_ba: cap_ba_i[h],
                    sel_ab: sel_ab_i[h],
                    sel_ba: sel_ba_i[h]};

    xcvr_half #(.W(HALF_W)) i_half (
      .clk_i,
      .rst_ni,
      .ctrl_i (ctrl),
      .a_i    (a_i   [h*HALF_W +: HALF_W]),
      .b_i    (b_i   [h*HALF_W +: HALF_W]),
      .a_o    (a_o   [h*HALF_W +: HALF_W]),
      .a_oe_o (a_oe_o[h*HALF_W +: HALF_W]),
      .b_o    (b_o   [h*HALF_W +: HALF_W]),
      .b_oe_o (b_oe_o[h*HALF_W +: HALF_W])
    );
  end
endmodule

// File: rtl/xcvr_regbus_chk.sv
module xcvr_regbus_chk #(
  parameter int HALF_W     = 8,
  parameter int NUM_HALVES = 2,
  localparam int W         = HALF_W * NUM_HALVES
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic [NUM_HALVES-1:0] oe_ni,
  input logic [NUM_HALVES-1:0] dir_i,
  input logic [NUM_HALVES-1:0] cap_ab_i,
  input logic [NUM_HALVES-1:0] cap_ba_i,
  input logic [NUM_HALVES-1:0] sel_ab_i,
  input logic [NUM_HALVES-1:0] sel_ba_i,
  input logic [W-1:0]          a_i,
  input logic [W-1:0]          a_o,
  input logic [W-1:0]          a_oe_o,
  input logic [W-1:0]          b_i,
  input logic [W-1:0]          b_o,
  input logic [W-1:0]          b_oe_o
);
  for (genvar h = 0; h < NUM_HALVES; h++) begin : g_h
    localparam int LO = h * HALF_W;

    a_r2_isolated: assert property (@(posedge clk_i) disable iff (!rst_ni)
      oe_ni[h] |-> (a_oe_o[LO +: HALF_W] == '0) && (b_oe_o[LO +: HALF_W] == '0));

    a_r3_one_side: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !((|a_oe_o[LO +: HALF_W]) && (|b_oe_o[LO +: HALF_W])));

    a_r3_drive_b: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!oe_ni[h] && dir_i[h]) |-> (&b_oe_o[LO +: HALF_W]));

    a_r4_live_ab: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!oe_ni[h] && dir_i[h] && !sel_ab_i[h]) |->
        (b_o[LO +: HALF_W] == a_i[LO +: HALF_W]));

    a_r5_live_ba: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!oe_ni[h] && !dir_i[h] && !sel_ba_i[h]) |->
        (a_o[LO +: HALF_W] == b_i[LO +: HALF_W]));

    a_r6_stored_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sel_ab_i[h] && $past(sel_ab_i[h]) && !$past(cap_ab_i[h])) |->
        $stable(b_o[LO +: HALF_W]));

    a_r7_stored_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sel_ba_i[h] && $past(sel_ba_i[h]) && !$past(cap_ba_i[h])) |->
        $stable(a_o[LO +: HALF_W]));
  end
endmodule

bind xcvr_regbus xcvr_regbus_chk #(.HALF_W(HALF_W), .NUM_HALVES(NUM_HALVES)) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .oe_ni(oe_ni), .dir_i(dir_i),
  .cap_ab_i(cap_ab_i), .cap_ba_i(cap_ba_i), .sel_ab_i(sel_ab_i), .sel_ba_i(sel_ba_i),
  .a_i(a_i), .a_o(a_o), .a_oe_o(a_oe_o), .b_i(b_i), .b_o(b_o), .b_oe_o(b_oe_o)
);

// File: tb/test_xcvr_regbus.sv
module test_xcvr_regbus;
  localparam int CLK_P = 10;
  localparam int HW    = 8;
  localparam int NH    = 2;
  localparam int W     = HW * NH;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NH-1:0] oe_n, dir, cab, cba, sab, sba;
  logic [W-1:0]  a_in, b_in, a_out, a_oe, b_out, b_oe;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  xcvr_regbus #(.HALF_W(HW), .NUM_HALVES(NH)) i_xcvr_regbus (
    .clk_i(clk), .rst_ni(rst_n), .oe_ni(oe_n), .dir_i(dir),
    .cap_ab_i(cab), .cap_ba_i(cba), .sel_ab_i(sab), .sel_ba_i(sba),
    .a_i(a_in), .a_o(a_out), .a_oe_o(a_oe),
    .b_i(b_in), .b_o(b_out), .b_oe_o(b_oe)
  );

  // behavioural reference
  logic [HW-1:0] m_ra [NH];
  logic [HW-1:0] m_rb [NH];
  bit            m_pab [NH];
  bit            m_pba [NH];

  function automatic logic [HW-1:0] exp_a(int h);
    return sba[h] ? m_rb[h] : b_in[h*HW +: HW];
  endfunction
  function automatic logic [HW-1:0] exp_b(int h);
    return sab[h] ? m_ra[h] : a_in[h*HW +: HW];
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int h = 0; h < NH; h++) begin
        m_ra[h] <= '0; m_rb[h] <= '0; m_pab[h] <= 1'b0; m_pba[h] <= 1'b0;
      end
    end else begin
      for (int h = 0; h < NH; h++) begin
        logic [HW-1:0] sa, sb;
        sa = (!oe_n[h] && !dir[h]) ? exp_a(h) : a_in[h*HW +: HW];
        sb = (!oe_n[h] &&  dir[h]) ? exp_b(h) : b_in[h*HW +: HW];
        if (cab[h] && !m_pab[h]) m_ra[h] <= sa;
        if (cba[h] && !m_pba[h]) m_rb[h] <= sb;
        m_pab[h] <= cab[h];
        m_pba[h] <= cba[h];
      end
    end
  end

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  // model comparison every cycle, mid-period
  always @(negedge clk) begin
    if (rst_n && !done) begin
      for (int h = 0; h < NH; h++) begin
        bit ea, eb;
        ea = !oe_n[h] && !dir[h];
        eb = !oe_n[h] &&  dir[h];
        chk("R2/R3 a_oe", a_oe[h*HW +: HW], {HW{ea}});
        chk("R2/R3 b_oe", b_oe[h*HW +: HW], {HW{eb}});
        if (ea) chk("R5/R7/R9 a_o", a_out[h*HW +: HW], exp_a(h));
        if (eb) chk("R4/R6/R9 b_o", b_out[h*HW +: HW], exp_b(h));
      end
    end
  end

  task automatic step(int n);
    repeat (n) @(posedge clk);
    #(CLK_P/4);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog act=hung exp=done");
    finish_run();
  end

  initial begin
    oe_n = '1; dir = '0; cab = '0; cba = '0; sab = '0; sba = '0;
    a_in = '0; b_in = '0;
    step(3);
    rst_n = 1'b1;

    // R1: reset contents in stored mode
    oe_n = 2'b00; dir = 2'b11; sab = 2'b11; sba = 2'b00;
    step(1);
    chk("R1 b_o after reset", b_out, 16'h0000);
    chk("R3 b_oe", b_oe, 16'hFFFF);
    chk("R3 a_oe", a_oe, 16'h0000);

    // R4 transparent A to B
    sab = 2'b00; a_in = 16'h1234;
    step(1);
    chk("R4 live b_o", b_out, 16'h1234);

    // R5 transparent B to A
    dir = 2'b00; sba = 2'b00; b_in = 16'hBEEF;
    step(1);
    chk("R5 live a_o", a_out, 16'hBEEF);
    chk("R3 a_oe dir low", a_oe, 16'hFFFF);

    // R6 capture and stored output
    dir = 2'b11; sab = 2'b11; a_in = 16'h5A3C; cab = 2'b11;
    step(1);
    cab = 2'b00;
    chk("R6 stored b_o", b_out, 16'h5A3C);
    a_in = 16'h0000;
    step(1);
    chk("R6 stored hold", b_out, 16'h5A3C);

    // R11 held strobe loads once
    cab = 2'b11; a_in = 16'h1111;
    step(1);
    a_in = 16'h2222;
    step(2);
    chk("R11 single load", b_out, 16'h1111);
    cab = 2'b00;
    step(1);

    // R8 capture while isolated
    oe_n = 2'b11; a_in = 16'h0F0F; b_in = 16'hF0F0; cab = 2'b11; cba = 2'b11;
    step(1);
    chk("R2 a_oe isolated", a_oe, 16'h0000);
    chk("R2 b_oe isolated", b_oe, 16'h0000);
    cab = 2'b00; cba = 2'b00; oe_n = 2'b00; dir = 2'b11; sab = 2'b11;
    step(1);
    chk("R8 A reg loaded in isolation", b_out, 16'h0F0F);
    dir = 2'b00; sba = 2'b11;
    step(1);
    chk("R7/R8 B reg loaded in isolation", a_out, 16'hF0F0);

    // R9 driven side captures driven value
    dir = 2'b00; sba = 2'b00; b_in = 16'h7788; a_in = 16'hFFFF; cab = 2'b11;
    step(1);
    cab = 2'b00; dir = 2'b11; sab = 2'b11;
    step(1);
    chk("R9 A reg holds driven value", b_out, 16'h7788);

    // R10 half independence
    oe_n = 2'b10; a_in = 16'hABCD; cab = 2'b10;
    step(1);
    cab = 2'b00;
    chk("R10 b_oe per half", b_oe, 16'h00FF);
    chk("R10 a_oe per half", a_oe, 16'h0000);
    oe_n = 2'b00;
    step(1);
    chk("R10 only upper half loaded", b_out, 16'hAB88);

    // random traffic judged by the model
    for (int i = 0; i < 4000; i++) begin
      oe_n = NH'($urandom); dir = NH'($urandom);
      cab = NH'($urandom); cba = NH'($urandom);
      sab = NH'($urandom); sba = NH'($urandom);
      a_in = W'($urandom); b_in = W'($urandom);
      step(1);
    end

    finish_run();
  end
endmodule